// File: doc/BRIEF.md
# Glitch-Free Programmable Clock Output

This block produces a single clock pin for external logic. In normal operation the pin carries a 48 MHz reference clock divided by an integer ratio. The ratio is N+1, where N is a 4-bit factor that software loads through a strobe.

A newly loaded factor is held in a pending register. It is applied only when the running output period has ended and the output is low. This way, reprogramming never shortens a pulse. A factor of zero sends the reference straight to the pin. For odd ratios, the high phase is the shorter half.

While the device is suspended, the pin can fall back to a slow low-power clock of about 30 kHz. The switch happens after a programmable delay, nominally 1 ms of reference cycles, unless a keep-fast control bit forbids it. Both the move to the slow source and the move back pass through a two-sided enable handshake. Each source is gated off or on only while it is low. The reference and the slow clock come from outside the block.

Top module: `pclk_gen`

## Requirements
- R1: The output period is (N+1) reference periods, where N is the factor in force.
- R2: During and after reset, the output is low, and the factor in force is 11, so the output period is 12 reference periods.
- R3: A loaded value greater than 11 is treated as 11.
- R4: A change on the factor input without a load strobe has no effect on the output.
- R5: A loaded factor takes effect only at the end of the current output period, while the divided output is low.
- R6: For N of 1 or more, the high phase lasts floor((N+1)/2) reference periods. For N of 0, the high phase is the reference high phase.
- R7: With N equal to 0, the output follows the reference clock, with a period of one reference period.
- R8: With keep-fast at 0, the output stays on the divided clock for the first LAZY_CYCLES reference cycles of suspend, and after that it carries the slow clock.
- R9: With keep-fast at 1, the output never switches to the slow clock, even during a long suspend.
- R10: When suspend is deasserted, the output returns to the divided clock.
- R11: No high or low pulse on the output is shorter than the reference high phase. This holds across factor changes and across source switches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | 48 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | DIV_W | Division factor N to load |
| div_load | input | 1 | One-cycle strobe that captures div_val, synchronous to ref_clk |
| keep_fast | input | 1 | 1 = never fall back to the slow clock |
| suspend | input | 1 | Device suspended, asynchronous |
| slow_clk | input | 1 | Slow low-power clock source |
| clk_out | output | 1 | Programmable clock output |

## Verification
A loaded factor appears within one old output period, which is at most 12 reference cycles. The bench therefore waits 40 reference cycles after each strobe before it times two rising edges and one falling edge of the output.

The slow-clock fallback has a longer latency. It takes two synchronizer cycles plus LAZY_CYCLES plus one reference cycle to raise the request, and then two fast and about three slow edges of handshake. The bench measures well inside the delay window to confirm that the output is still fast. It measures again about 250 reference cycles after suspend to confirm that the output is slow.

The return to the divided clock is measured 100 reference cycles after suspend falls. A pulse-width monitor watches every output edge for the whole run.

// File: rtl/pclk_pkg.sv
`timescale 1ns/1ps
package pclk_pkg;
   // default geometry of the clock output block
   localparam int unsigned DEF_DIV_W   = 4;
   localparam int unsigned DEF_MAX_DIV = 11;
   localparam int unsigned DEF_LAZY    = 48000;   // 1 ms of 48 MHz
   localparam int unsigned DEF_SYNC    = 2;
endpackage

// File: rtl/pclk_sync.sv
`timescale 1ns/1ps
module pclk_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pclk_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pclk_div.sv
`timescale 1ns/1ps
module pclk_div #(
   parameter int unsigned DIV_W     = 4,
   parameter int unsigned MAX_DIV   = 11,
   parameter int unsigned RESET_DIV = 11
) (
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   input  logic             div_load,
   output logic             fast_clk
);
   if (MAX_DIV >= (1 << DIV_W)) begin : g_bad_max
      $error("pclk_div: MAX_DIV does not fit in DIV_W bits");
   end
   if (RESET_DIV > MAX_DIV) begin : g_bad_rst
      $error("pclk_div: RESET_DIV exceeds MAX_DIV");
   end

   localparam logic [DIV_W-1:0] MAXV = DIV_W'(MAX_DIV);
   localparam logic [DIV_W-1:0] RSTV = DIV_W'(RESET_DIV);

   logic [DIV_W-1:0] pend_n;
   logic [DIV_W-1:0] cur_n;
   logic [DIV_W-1:0] cnt;
   logic [DIV_W:0]   hi_len;
   logic             period_end;
   logic             div_q;
   logic             use_ref_q;

   assign hi_len     = ({1'b0, cur_n} + 1'b1) >> 1;
   assign period_end = (cnt == cur_n);

   // pending factor, clamped on capture
   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n)        pend_n <= RSTV;
      else if (div_load) pend_n <= (div_val > MAXV) ? MAXV : div_val;
   end

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_n <= RSTV;
         cnt   <= '0;
         div_q <= 1'b0;
      end else if (period_end) begin
         cur_n <= pend_n;
         cnt   <= '0;
         div_q <= (pend_n != '0);
      end else begin
         cnt   <= cnt + 1'b1;
         div_q <= (({1'b0, cnt} + 1'b1) < hi_len);
      end
   end

   // bypass enable changes while the reference is low
   always_ff @(negedge ref_clk or negedge rst_n) begin
      if (!rst_n) use_ref_q <= 1'b0;
      else        use_ref_q <= (cur_n == '0);
   end

   assign fast_clk = div_q | (ref_clk & use_ref_q);

   // R3
   div_range_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      cur_n <= MAXV);

   // R5
   div_boundary_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (cur_n != $past(cur_n)) |-> ($past(cnt) == $past(cur_n)));

   // R5
   div_low_at_end_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (period_end && cur_n != '0) |-> !div_q);
endmodule

// File: rtl/pclk_susp_timer.sv
`timescale 1ns/1ps
module pclk_susp_timer #(
   parameter int unsigned LAZY_CYCLES = 48000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic suspend,
   input  logic keep_fast,
   output logic want_slow
);
   if (LAZY_CYCLES < 1) begin : g_bad_lazy
      $error("pclk_susp_timer: LAZY_CYCLES must be positive");
   end

   localparam int unsigned CW = $clog2(LAZY_CYCLES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(LAZY_CYCLES);

   logic          susp_s;
   logic [CW-1:0] cnt;

   pclk_sync #(.STAGES(SYNC_STAGES)) u_susp_sync (
      .clk(ref_clk), .rst_n(rst_n), .d(suspend), .q(susp_s)
   );

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         want_slow <= 1'b0;
      end else begin
         if (!susp_s)           cnt <= '0;
         else if (cnt != LIMIT) cnt <= cnt + 1'b1;
         want_slow <= susp_s & ~keep_fast & (cnt == LIMIT);
      end
   end

   // R9
   keep_fast_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      keep_fast |=> !want_slow);

   // R8
   lazy_delay_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(want_slow) |-> $past(cnt == LIMIT));

   // R10
   wake_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !susp_s |=> !want_slow);
endmodule

// File: rtl/pclk_src_mux.sv
`timescale 1ns/1ps
module pclk_src_mux #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic rst_n,
   input  logic fast_clk,
   input  logic slow_clk,
   input  logic want_slow,
   output logic clk_out
);
   logic f_req, f_en, s_en, s_en_fs, s_req;

   // fast side: request needs slow side idle
   pclk_sync #(.STAGES(SYNC_STAGES)) u_sen_sync (
      .clk(fast_clk), .rst_n(rst_n), .d(s_en), .q(s_en_fs)
   );

   always_ff @(posedge fast_clk or negedge rst_n) begin
      if (!rst_n) f_req <= 1'b1;
      else        f_req <= ~want_slow & ~s_en_fs;
   end

   always_ff @(negedge fast_clk or negedge rst_n) begin
      if (!rst_n) f_en <= 1'b1;
      else        f_en <= f_req;
   end

   // slow side: request needs fast side idle
   pclk_sync #(.STAGES(SYNC_STAGES)) u_sreq_sync (
      .clk(slow_clk), .rst_n(rst_n), .d(want_slow & ~f_en), .q(s_req)
   );

   always_ff @(negedge slow_clk or negedge rst_n) begin
      if (!rst_n) s_en <= 1'b0;
      else        s_en <= s_req;
   end

   assign clk_out = (fast_clk & f_en) | (slow_clk & s_en);

   // R11
   always_comb begin
      src_excl_chk: assert (!(f_en && s_en));
   end
endmodule

// File: rtl/pclk_gen.sv
`timescale 1ns/1ps
module pclk_gen import pclk_pkg::*; #(
   parameter int unsigned DIV_W       = DEF_DIV_W,
   parameter int unsigned MAX_DIV     = DEF_MAX_DIV,
   parameter int unsigned RESET_DIV   = DEF_MAX_DIV,
   parameter int unsigned LAZY_CYCLES = DEF_LAZY,
   parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   input  logic             div_load,
   input  logic             keep_fast,
   input  logic             suspend,
   input  logic             slow_clk,
   output logic             clk_out
);
   logic fast_clk;
   logic want_slow;

   pclk_div #(
      .DIV_W(DIV_W), .MAX_DIV(MAX_DIV), .RESET_DIV(RESET_DIV)
   ) u_div (
      .ref_clk(ref_clk), .rst_n(rst_n), .div_val(div_val),
      .div_load(div_load), .fast_clk(fast_clk)
   );

   pclk_susp_timer #(
      .LAZY_CYCLES(LAZY_CYCLES), .SYNC_STAGES(SYNC_STAGES)
   ) u_timer (
      .ref_clk(ref_clk), .rst_n(rst_n), .suspend(suspend),
      .keep_fast(keep_fast), .want_slow(want_slow)
   );

   pclk_src_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
      .rst_n(rst_n), .fast_clk(fast_clk), .slow_clk(slow_clk),
      .want_slow(want_slow), .clk_out(clk_out)
   );
endmodule

// File: tb/pclk_gen_tb_top.sv
`timescale 1ns/1ps
module pclk_gen_tb_top;
   localparam int NVEC = 8;
   // factor, expected period (ns), expected high time (tenths of ns)
   localparam int VEC_N  [NVEC] = '{11, 0, 1, 2, 5, 7, 14, 3};
   localparam int VEC_PER[NVEC] = '{60, 5, 10, 15, 30, 40, 60, 20};
   localparam int VEC_HI [NVEC] = '{300, 25, 50, 50, 150, 200, 300, 100};

   logic       ref_clk = 1'b0;
   logic       slow_clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] div_val = 4'd0;
   logic       div_load = 1'b0;
   logic       keep_fast = 1'b0;
   logic       suspend = 1'b0;
   logic       clk_out;

   int  n_chk = 0;
   int  n_fail = 0;
   int  glitches = 0;
   bit  mon_en = 1'b0;
   bit  done = 1'b0;
   real last_edge = 0.0;
   real per, hi;

   always #2.5 ref_clk = ~ref_clk;
   always #19  slow_clk = ~slow_clk;

   pclk_gen #(.LAZY_CYCLES(64)) dut_i (
      .ref_clk(ref_clk), .rst_n(rst_n), .div_val(div_val),
      .div_load(div_load), .keep_fast(keep_fast), .suspend(suspend),
      .slow_clk(slow_clk), .clk_out(clk_out)
   );

   // R11 pulse-width monitor
   always @(clk_out) begin
      if (mon_en && ($realtime - last_edge) < 2.4) glitches++;
      last_edge = $realtime;
   end

   task automatic chk(input bit ok, input string tag, input real act, input real exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0.3f expected=%0.3f", tag, act, exp);
      end
   endtask

   function automatic bit near(input real a, input real b);
      return (a - b < 0.05) && (b - a < 0.05);
   endfunction

   task automatic measure(output real p, output real h);
      real t0, t1, t2;
      @(posedge clk_out) t0 = $realtime;
      @(negedge clk_out) t1 = $realtime;
      @(posedge clk_out) t2 = $realtime;
      p = t2 - t0;
      h = t1 - t0;
   endtask

   task automatic load(input int n);
      @(negedge ref_clk);
      div_val  = 4'(n);
      div_load = 1'b1;
      @(negedge ref_clk);
      div_load = 1'b0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired, no requirement completed");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // R2 reset state
      #12;
      chk(clk_out == 1'b0, "R2 output low in reset", real'(clk_out), 0.0);
      @(negedge ref_clk);
      rst_n = 1'b1;
      mon_en = 1'b1;
      repeat (30) @(negedge ref_clk);
      measure(per, hi);
      chk(near(per, 60.0), "R2 reset period", per, 60.0);

      // table walk: R1 R3 R6 R7
      for (int i = 0; i < NVEC; i++) begin
         load(VEC_N[i]);
         repeat (40) @(negedge ref_clk);
         measure(per, hi);
         chk(near(per, real'(VEC_PER[i])),
             (VEC_N[i] == 0) ? "R7 period" : (VEC_N[i] > 11) ? "R3 clamp period" : "R1 period",
             per, real'(VEC_PER[i]));
         chk(near(hi, real'(VEC_HI[i]) / 10.0), "R6 high time", hi, real'(VEC_HI[i]) / 10.0);
      end

      // R4 factor input without strobe is ignored
      @(negedge ref_clk) div_val = 4'd2;
      repeat (40) @(negedge ref_clk);
      measure(per, hi);
      chk(near(per, 20.0), "R4 no strobe no change", per, 20.0);

      // R5 load mid-period, applied at boundary
      @(posedge clk_out);
      @(negedge ref_clk);
      div_val = 4'd5; div_load = 1'b1;
      @(negedge ref_clk) div_load = 1'b0;
      repeat (40) @(negedge ref_clk);
      measure(per, hi);
      chk(near(per, 30.0), "R5 mid-period load", per, 30.0);

      // R8 lazy switch
      @(negedge ref_clk) suspend = 1'b1;
      repeat (20) @(negedge ref_clk);
      measure(per, hi);
      chk(near(per, 30.0), "R8 fast within delay", per, 30.0);
      repeat (250) @(negedge ref_clk);
      measure(per, hi);
      chk(near(per, 38.0), "R8 slow after delay", per, 38.0);

      // R10 wake
      @(negedge ref_clk) suspend = 1'b0;
      repeat (100) @(negedge ref_clk);
      measure(per, hi);
      chk(near(per, 30.0), "R10 back to fast", per, 30.0);

      // R9 keep_fast forbids slow
      @(negedge ref_clk) begin keep_fast = 1'b1; suspend = 1'b1; end
      repeat (300) @(negedge ref_clk);
      measure(per, hi);
      chk(near(per, 30.0), "R9 keep_fast stays fast", per, 30.0);
      @(negedge ref_clk) begin suspend = 1'b0; keep_fast = 1'b0; end
      repeat (40) @(negedge ref_clk);

      // R11 no runt pulses during the whole run
      chk(glitches == 0, "R11 runt pulses", real'(glitches), 0.0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule